// File: doc/BRIEF.md
# Multi-Mode Up/Down Interval Timer

This block is a 16-bit interval counter driven by a two-stage tick prescaler. A mode field picks one of four behaviours: halted, counting up to a programmable period and wrapping, free-running to a maximum set by a selectable counter length, or triangle counting that climbs to the period and falls back to zero. The counter advances only on prescaled steps of an external tick enable, so one system clock serves every rate.

The period value can be rewritten while the counter runs. The counter either continues into the new period or wraps at once, depending on where it stands. A sticky rollover flag records each wrap to zero and, gated by an enable, drives an interrupt output. A period-match pulse marks every step that lands on the period value. A clear strobe restarts the count, the direction and the prescaler from a known state.

Top module: `ivt_timer`

## Requirements
- R1: After reset the count is 0, the direction output is 0 (up), and the match, rollover flag and interrupt outputs are 0.
- R2: With mode code 00 (halt) the count and the direction do not change, whatever the tick input does.
- R3: With mode code 01 each step adds one while the count is below the period value. A step taken at or above the period value sets the count to 0 and sets the rollover flag, so a full cycle holds period+1 counts.
- R4: With mode code 10 each step adds one up to a maximum given by the length code (00: 16'hFFFF, 01: 16'h0FFF, 10: 16'h03FF, 11: 16'h00FF). A step taken at or above that maximum sets the count to 0 and sets the rollover flag.
- R5: With mode code 11 the count rises to the period value and then falls. The direction output is 1 while the counter falls. The step that brings a falling count to 0 sets the rollover flag and returns the direction to 0.
- R6: A step happens once every (2^A)*(B+1) cycles in which the tick input is high, where A is the 2-bit first-stage code and B is the 3-bit second-stage code. Cycles with the tick input low neither step nor advance the prescaler.
- R7: The match output is high for exactly the one cycle after any step whose new count equals the period value, in every running mode.
- R8: In mode 01, if the period is rewritten to a value at least the current count, the running cycle ends at the new value. If it is rewritten below the current count, the next step goes to 0 and sets the rollover flag.
- R9: In mode 11 a period change made while falling has no effect until the count reaches 0. If, while rising, the period becomes lower than the count, the next step counts down by one and sets the direction to 1.
- R10: Leaving mode 11 for halt and coming back resumes from the held count in the held direction.
- R11: A clear strobe sets the count to 0, the direction to up and both prescaler stages to their start in the next cycle, taking priority over any step; the rollover flag is left as it is.
- R12: The rollover flag stays set until the flag-clear input is high at a clock edge. A rollover in that same cycle wins and keeps the flag set. The interrupt output is the flag ANDed with the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Count-enable tick feeding the prescaler |
| mode_i | input | 2 | Mode: 00 halt, 01 up, 10 free-run, 11 up/down |
| pre_div_i | input | 2 | First prescaler stage code: divide by 2^code |
| post_div_i | input | 3 | Second prescaler stage code: divide by code+1 |
| len_sel_i | input | 2 | Counter length for free-run: 00 16, 01 12, 10 10, 11 8 bits |
| period_i | input | 16 | Period value |
| clear_i | input | 1 | One-cycle clear strobe for count, direction and prescaler |
| flag_clr_i | input | 1 | Clears the rollover flag |
| irq_en_i | input | 1 | Interrupt enable |
| count_o | output | 16 | Current count |
| dir_down_o | output | 1 | 1 while counting down |
| match_o | output | 1 | One-cycle pulse after a step onto the period value |
| roll_flag_o | output | 1 | Sticky rollover flag |
| irq_o | output | 1 | Rollover flag gated by the enable |

## Verification
The rollover event and the software flag clear can land on the same clock edge. The bench sets the flag-clear input exactly on the step that wraps the count to zero and expects the flag, and with the enable high the interrupt, to stay set. A clear strobe can also meet a pending prescaler step. The bench places it part-way through a divide-by-six sequence and requires a full six ticks before the next step, which shows the prescaler restarted instead of finishing its old sequence.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [1:0] {
        MODE_HALT = 2'b00,
        MODE_UP   = 2'b01,
        MODE_FREE = 2'b10,
        MODE_TRI  = 2'b11
    } ivt_mode_e;

    typedef enum logic [1:0] {
        LEN_16 = 2'b00,
        LEN_12 = 2'b01,
        LEN_10 = 2'b10,
        LEN_8  = 2'b11
    } ivt_len_e;

endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
    parameter int A_CODE_W    = 2,
    parameter int B_CODE_W    = 3,
    parameter bit HAS_STAGE_B = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                run,
    input  logic                tick,
    input  logic [A_CODE_W-1:0] div_a,
    input  logic [B_CODE_W-1:0] div_b,
    output logic                step
);
    localparam int A_CNT_W = (2 ** A_CODE_W) - 1;

    typedef struct packed {
        logic [A_CNT_W-1:0]  a;
        logic [B_CODE_W-1:0] b;
    } pre_state_t;

    pre_state_t         st_d, st_q;
    logic               pulse_a;
    logic [A_CNT_W-1:0] lim_a;

    assign lim_a = A_CNT_W'((1 << div_a) - 1);

    // stage A: power-of-two divider
    always_comb begin
        pulse_a = 1'b0;
        st_d.a  = st_q.a;
        if (clear) begin
            st_d.a = '0;
        end else if (run && tick) begin
            if (st_q.a >= lim_a) begin
                st_d.a  = '0;
                pulse_a = 1'b1;
            end else begin
                st_d.a = st_q.a + A_CNT_W'(1);
            end
        end
    end

    // stage B: optional linear divider
    generate
        if (HAS_STAGE_B) begin : g_stage_b
            always_comb begin
                step   = 1'b0;
                st_d.b = st_q.b;
                if (clear) begin
                    st_d.b = '0;
                end else if (pulse_a) begin
                    if (st_q.b >= div_b) begin
                        st_d.b = '0;
                        step   = 1'b1;
                    end else begin
                        st_d.b = st_q.b + B_CODE_W'(1);
                    end
                end
            end
        end else begin : g_no_stage_b
            always_comb begin
                st_d.b = '0;
                step   = pulse_a;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: a clear leaves both stages at their start
    assert_pre_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> (st_q == '0));

endmodule

// File: rtl/ivt_core.sv
module ivt_core
    import ivt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  ivt_mode_e        mode,
    input  ivt_len_e         len_sel,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             match,
    output logic             wrap
);
    localparam int SH_12 = (CNT_W > 12) ? CNT_W - 12 : 0;
    localparam int SH_10 = (CNT_W > 10) ? CNT_W - 10 : 0;
    localparam int SH_8  = (CNT_W > 8)  ? CNT_W - 8  : 0;
    localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             match;
    } core_state_t;

    core_state_t      st_d, st_q;
    logic [CNT_W-1:0] lim;

    // free-run maximum from the length code
    always_comb begin
        case (len_sel)
            LEN_12:  lim = ALL_ONES >> SH_12;
            LEN_10:  lim = ALL_ONES >> SH_10;
            LEN_8:   lim = ALL_ONES >> SH_8;
            default: lim = ALL_ONES;
        endcase
    end

    always_comb begin
        st_d       = st_q;
        st_d.match = 1'b0;
        wrap       = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
            st_d.dir = 1'b0;
        end else if (step) begin
            case (mode)
                MODE_UP: begin
                    st_d.dir = 1'b0;
                    if (st_q.cnt >= period) begin
                        st_d.cnt = '0;
                        wrap     = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                MODE_FREE: begin
                    st_d.dir = 1'b0;
                    if (st_q.cnt >= lim) begin
                        st_d.cnt = '0;
                        wrap     = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt + CNT_W'(1);
                    end
                end
                MODE_TRI: begin
                    if (!st_q.dir) begin
                        if (st_q.cnt >= period) begin
                            st_d.dir = 1'b1;
                            st_d.cnt = (st_q.cnt == '0) ? '0 : st_q.cnt - CNT_W'(1);
                        end else begin
                            st_d.cnt = st_q.cnt + CNT_W'(1);
                        end
                    end else if (st_q.cnt == '0) begin
                        st_d.dir = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt - CNT_W'(1);
                        if (st_q.cnt == CNT_W'(1)) begin
                            st_d.dir = 1'b0;
                            wrap     = 1'b1;
                        end
                    end
                end
                default: ;
            endcase
            st_d.match = (mode != MODE_HALT) && (st_d.cnt == period);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count    = st_q.cnt;
    assign dir_down = st_q.dir;
    assign match    = st_q.match;

    // R7: a match pulse only follows a step onto the period
    assert_match_on_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.match |-> (st_q.cnt == $past(period)));

    // R11: clear forces count zero and upward direction
    assert_clear_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear) |-> (st_q.cnt == '0 && !st_q.dir));

    // R2: halt keeps count and direction
    assert_halt_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HALT && !clear) |=> ($stable(st_q.cnt) && $stable(st_q.dir)));

    // R5: direction changes only at a turn point or a clear
    assert_turn_points_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($changed(st_q.dir) && !$past(clear)) |-> (st_q.dir || st_q.cnt == '0));

endmodule

// File: rtl/ivt_flag.sv
module ivt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic en,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic roll;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set)      st_d.roll = 1'b1;
        else if (clr) st_d.roll = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.roll;
    assign irq  = st_q.roll & en;

    // R12: a rollover on the clearing edge leaves the flag set
    assert_set_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int A_CODE_W = 2,
    parameter int B_CODE_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_en_i,
    input  logic [1:0]          mode_i,
    input  logic [A_CODE_W-1:0] pre_div_i,
    input  logic [B_CODE_W-1:0] post_div_i,
    input  logic [1:0]          len_sel_i,
    input  logic [CNT_W-1:0]    period_i,
    input  logic                clear_i,
    input  logic                flag_clr_i,
    input  logic                irq_en_i,
    output logic [CNT_W-1:0]    count_o,
    output logic                dir_down_o,
    output logic                match_o,
    output logic                roll_flag_o,
    output logic                irq_o
);
    ivt_mode_e mode;
    ivt_len_e  len_sel;
    logic      step;
    logic      wrap;

    assign mode    = ivt_mode_e'(mode_i);
    assign len_sel = ivt_len_e'(len_sel_i);

    ivt_prescale #(
        .A_CODE_W    (A_CODE_W),
        .B_CODE_W    (B_CODE_W),
        .HAS_STAGE_B (1'b1)
    ) prescale_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear_i),
        .run   (mode != MODE_HALT),
        .tick  (tick_en_i),
        .div_a (pre_div_i),
        .div_b (post_div_i),
        .step  (step)
    );

    ivt_core #(
        .CNT_W (CNT_W)
    ) core_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear_i),
        .step     (step),
        .mode     (mode),
        .len_sel  (len_sel),
        .period   (period_i),
        .count    (count_o),
        .dir_down (dir_down_o),
        .match    (match_o),
        .wrap     (wrap)
    );

    ivt_flag flag_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wrap),
        .clr   (flag_clr_i),
        .en    (irq_en_i),
        .flag  (roll_flag_o),
        .irq   (irq_o)
    );

    // R12: the flag only rises on a wrap to zero
    assert_flag_rise_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(roll_flag_o) |-> (count_o == '0));

endmodule

// File: tb/ivt_timer_tb_top.sv
`timescale 1ns/1ps
module ivt_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [1:0]  pre_div = 2'd0;
    logic [2:0]  post_div = 3'd0;
    logic [1:0]  len_sel = 2'b00;
    logic [15:0] period = 16'd0;
    logic        clear = 1'b0;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic [15:0] count;
    logic        dir_down, match, roll_flag, irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] cnt;
        logic        dir;
        logic        roll;
        logic        match;
        logic        irq;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #2.5 clk = ~clk;

    ivt_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en_i   (tick_en),
        .mode_i      (mode),
        .pre_div_i   (pre_div),
        .post_div_i  (post_div),
        .len_sel_i   (len_sel),
        .period_i    (period),
        .clear_i     (clear),
        .flag_clr_i  (flag_clr),
        .irq_en_i    (irq_en),
        .count_o     (count),
        .dir_down_o  (dir_down),
        .match_o     (match),
        .roll_flag_o (roll_flag),
        .irq_o       (irq)
    );

    // driver: queue the expectation for the coming edge, then let it pass
    task automatic chk(input logic [15:0] c, input logic d, input logic r,
                       input logic m, input logic i, input string tag);
        item_t it;
        it.cnt = c; it.dir = d; it.roll = r; it.match = m; it.irq = i; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks++;
                if (count !== it.cnt || dir_down !== it.dir || roll_flag !== it.roll ||
                    match !== it.match || irq !== it.irq) begin
                    n_fails++;
                    $display("FAIL %s: got cnt=%0d dir=%0b roll=%0b match=%0b irq=%0b, expected cnt=%0d dir=%0b roll=%0b match=%0b irq=%0b",
                             it.tag, count, dir_down, roll_flag, match, irq,
                             it.cnt, it.dir, it.roll, it.match, it.irq);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog: got no end, expected end of sequence");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick_en = 1'b1;
        chk(0, 0, 0, 0, 0, "R1 reset state");
        chk(0, 0, 0, 0, 0, "R2 halt with ticks");

        // up mode, period 3
        period = 16'd3; mode = 2'b01;
        chk(1, 0, 0, 0, 0, "R3 up");
        chk(2, 0, 0, 0, 0, "R3 up");
        chk(3, 0, 0, 1, 0, "R7 match up");
        chk(0, 0, 1, 0, 0, "R3 wrap sets flag");
        chk(1, 0, 1, 0, 0, "R12 flag sticky");
        flag_clr = 1'b1;
        chk(2, 0, 0, 0, 0, "R12 flag cleared");
        flag_clr = 1'b0;
        chk(3, 0, 0, 1, 0, "R7 match");
        flag_clr = 1'b1; irq_en = 1'b1;
        chk(0, 0, 1, 0, 1, "R12 set beats clear");
        flag_clr = 1'b0;
        chk(1, 0, 1, 0, 1, "R12 irq enabled");
        irq_en = 1'b0;
        chk(2, 0, 1, 0, 0, "R12 irq masked");
        flag_clr = 1'b1;
        chk(3, 0, 0, 1, 0, "R12 clear");
        flag_clr = 1'b0;
        chk(0, 0, 1, 0, 0, "R3 wrap");
        flag_clr = 1'b1;
        chk(1, 0, 0, 0, 0, "R12 clear");
        flag_clr = 1'b0;

        // period rewrites in up mode
        period = 16'd6;
        chk(2, 0, 0, 0, 0, "R8 larger period");
        chk(3, 0, 0, 0, 0, "R8 larger period");
        chk(4, 0, 0, 0, 0, "R8 larger period");
        chk(5, 0, 0, 0, 0, "R8 larger period");
        chk(6, 0, 0, 1, 0, "R8 new period match");
        chk(0, 0, 1, 0, 0, "R8 wrap at new period");
        flag_clr = 1'b1;
        chk(1, 0, 0, 0, 0, "R12 clear");
        flag_clr = 1'b0;
        chk(2, 0, 0, 0, 0, "R3 up");
        chk(3, 0, 0, 0, 0, "R3 up");
        chk(4, 0, 0, 0, 0, "R3 up");
        period = 16'd2;
        chk(0, 0, 1, 0, 0, "R8 period below count");
        chk(1, 0, 1, 0, 0, "R8 after rewrite");
        chk(2, 0, 1, 1, 0, "R8 match new period");
        chk(0, 0, 1, 0, 0, "R8 wrap new period");

        // free-run at each length
        mode = 2'b10; len_sel = 2'b11; period = 16'd128;
        clear = 1'b1; flag_clr = 1'b1;
        chk(0, 0, 0, 0, 0, "R11 clear");
        clear = 1'b0; flag_clr = 1'b0;
        idle(126);
        chk(127, 0, 0, 0, 0, "R4 free-run");
        chk(128, 0, 0, 1, 0, "R7 match free-run");
        idle(126);
        chk(255, 0, 0, 0, 0, "R4 8-bit maximum");
        chk(0, 0, 1, 0, 0, "R4 8-bit wrap");
        len_sel = 2'b10; flag_clr = 1'b1;
        chk(1, 0, 0, 0, 0, "R4 10-bit start");
        flag_clr = 1'b0;
        idle(1020);
        chk(1022, 0, 0, 0, 0, "R4 10-bit");
        chk(1023, 0, 0, 0, 0, "R4 10-bit maximum");
        chk(0, 0, 1, 0, 0, "R4 10-bit wrap");
        len_sel = 2'b01; flag_clr = 1'b1;
        chk(1, 0, 0, 0, 0, "R4 12-bit start");
        flag_clr = 1'b0;
        idle(4093);
        chk(4095, 0, 0, 0, 0, "R4 12-bit maximum");
        chk(0, 0, 1, 0, 0, "R4 12-bit wrap");
        len_sel = 2'b00; flag_clr = 1'b1;
        chk(1, 0, 0, 0, 0, "R4 16-bit start");
        flag_clr = 1'b0;
        idle(65533);
        chk(65535, 0, 0, 0, 0, "R4 16-bit maximum");
        chk(0, 0, 1, 0, 0, "R4 16-bit wrap");

        // prescaler: divide by 2 then by 3
        mode = 2'b01; period = 16'd100; pre_div = 2'd1; post_div = 3'd2;
        clear = 1'b1; flag_clr = 1'b1;
        chk(0, 0, 0, 0, 0, "R11 clear");
        clear = 1'b0; flag_clr = 1'b0;
        repeat (5) chk(0, 0, 0, 0, 0, "R6 no step before six ticks");
        chk(1, 0, 0, 0, 0, "R6 step on sixth tick");
        tick_en = 1'b0;
        repeat (3) chk(1, 0, 0, 0, 0, "R6 tick low no step");
        tick_en = 1'b1;
        repeat (5) chk(1, 0, 0, 0, 0, "R6 prescaler held");
        chk(2, 0, 0, 0, 0, "R6 second step");
        repeat (3) chk(2, 0, 0, 0, 0, "R6 partial sequence");
        clear = 1'b1;
        chk(0, 0, 0, 0, 0, "R11 clear mid prescale");
        clear = 1'b0;
        repeat (5) chk(0, 0, 0, 0, 0, "R11 prescaler restarted");
        chk(1, 0, 0, 0, 0, "R11 full six ticks");

        // up/down mode
        pre_div = 2'd0; post_div = 3'd0; mode = 2'b11; period = 16'd3;
        clear = 1'b1; flag_clr = 1'b1;
        chk(0, 0, 0, 0, 0, "R11 clear");
        clear = 1'b0; flag_clr = 1'b0;
        chk(1, 0, 0, 0, 0, "R5 rising");
        chk(2, 0, 0, 0, 0, "R5 rising");
        chk(3, 0, 0, 1, 0, "R7 match up/down");
        chk(2, 1, 0, 0, 0, "R5 turn down");
        chk(1, 1, 0, 0, 0, "R5 falling");
        chk(0, 0, 1, 0, 0, "R5 zero sets flag and turns up");
        chk(1, 0, 1, 0, 0, "R5 rising again");
        chk(2, 0, 1, 0, 0, "R5 rising again");
        chk(3, 0, 1, 1, 0, "R5 top");
        chk(2, 1, 1, 0, 0, "R5 falling");
        mode = 2'b00;
        chk(2, 1, 1, 0, 0, "R10 halt holds count and direction");
        chk(2, 1, 1, 0, 0, "R10 halt holds count and direction");
        mode = 2'b11;
        chk(1, 1, 1, 0, 0, "R10 resumes falling");
        chk(0, 0, 1, 0, 0, "R10 reaches zero");
        flag_clr = 1'b1;
        chk(1, 0, 0, 0, 0, "R12 clear");
        flag_clr = 1'b0;
        chk(2, 0, 0, 0, 0, "R5 rising");
        chk(3, 0, 0, 1, 0, "R5 top");
        chk(2, 1, 0, 0, 0, "R5 falling");
        period = 16'd10;
        chk(1, 1, 0, 0, 0, "R9 period change ignored while falling");
        chk(0, 0, 1, 0, 0, "R9 falling reaches zero");
        flag_clr = 1'b1;
        chk(1, 0, 0, 0, 0, "R12 clear");
        flag_clr = 1'b0;
        chk(2, 0, 0, 0, 0, "R9 rising under new period");
        chk(3, 0, 0, 0, 0, "R9 rising past old period");
        chk(4, 0, 0, 0, 0, "R9 rising");
        period = 16'd2;
        chk(3, 1, 0, 0, 0, "R9 smaller period turns down");
        chk(2, 1, 0, 1, 0, "R7 match while falling");
        chk(1, 1, 0, 0, 0, "R9 falling");
        chk(0, 0, 1, 0, 0, "R9 zero");
        chk(1, 0, 1, 0, 0, "R9 rising");
        chk(2, 0, 1, 1, 0, "R9 top at new period");
        chk(1, 1, 1, 0, 0, "R9 falling from new period");
        clear = 1'b1;
        chk(0, 0, 1, 0, 0, "R11 clear resets direction, keeps flag");
        clear = 1'b0;

        @(negedge clk);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule